// File: doc/BRIEF.md
# Reconfigurable Self-Test Register

A register of `WIDTH` flip-flops that a 2-bit mode input switches, cycle by cycle, between four roles. It can hold an ordinary parallel-loaded value, run freely as an internal-XOR linear feedback shift register that generates pseudo-random test patterns, fold a parallel response word into its state each cycle so that it builds a signature, or act as a serial scan chain for loading and unloading its contents.

The feedback polynomial is fixed by a parameter. In the shift roles, bit 0 moves toward bit `WIDTH-1`. The top bit feeds back into bit 0 and into every bit whose coefficient is set. A bit with a zero coefficient is a plain shift stage. A synchronous reset loads a seed value, zero by default, which is the usual starting point for signature compaction. Pattern generation never stays in the all-zero state: when it starts from zero, it substitutes a seed of 1. The surrounding test controller drives the circuit under test and compares signatures. Neither task is part of this block.

Top module: `bist_reg`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes `SEED` (default all zeros), whatever the mode.
- R2: With `mode` = 2'b11 (normal), the state takes `par_in` at the next edge.
- R3: With `mode` = 2'b00 (scan), bit 0 takes `scan_in` and bit i takes bit i-1 at each edge. `scan_out` always shows state bit `WIDTH-1`.
- R4: With `mode` = 2'b10 (pattern) and a nonzero state, the next state is the state multiplied by x modulo the characteristic polynomial. The polynomial is x^WIDTH + the `TAPS` coefficients for x^1..x^(WIDTH-1) + 1, and the default is x^8+x^4+x^3+x^2+1 (`TAPS` = 8'h1D). Bit 0 takes the old top bit. Bit i takes bit i-1, XORed with the old top bit only where `TAPS[i]` is 1.
- R5: With `mode` = 2'b10 and an all-zero state, the next state is 1 (only bit 0 set).
- R6: With the default primitive polynomial, pattern mode started from state 1 returns to 1 after exactly 255 steps and never passes through zero.
- R7: With `mode` = 2'b01 (signature), the next state is the R4 step of the state XORed with `par_in`. From a zero seed, a bit stream fed on `par_in[0]` leaves the remainder of the stream polynomial (first bit is the highest power) divided by the characteristic polynomial.
- R8: In signature mode, an all-zero state with an all-zero `par_in` stays zero. No seed is substituted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, loads `SEED` |
| mode | input | 2 | 00 scan, 01 signature, 10 pattern, 11 normal load |
| par_in | input | WIDTH | Parallel load data or response word |
| scan_in | input | 1 | Serial input into bit 0 |
| par_out | output | WIDTH | Current register state |
| scan_out | output | 1 | Serial output, state bit WIDTH-1 |

## Verification
Every state change lands one clock edge after the mode and data that cause it, and `scan_out` follows the state with no extra delay. The bench drives its inputs at the falling edge and lets one rising edge pass. It then steps a behavioural polynomial model by that same single edge and compares both outputs at the next falling edge, so the checks are always aligned to the one-cycle latency. The period and remainder checks are counted or computed over whole sequences, and they are judged only after the final edge of each sequence.

// File: rtl/bist_reg.sv
module bist_reg #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'h1D,
  parameter logic [WIDTH-1:0] SEED  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] par_out,
  output logic             scan_out
);
  localparam logic [1:0] M_SCAN = 2'b00;
  localparam logic [1:0] M_SIG  = 2'b01;
  localparam logic [1:0] M_GEN  = 2'b10;
  localparam logic [1:0] M_LOAD = 2'b11;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] st, step, d_in, nxt;
  logic             fb;

  assign fb   = st[WIDTH-1];
  assign d_in = (mode == M_SIG) ? par_in : '0;
  assign step[0] = fb ^ d_in[0];

  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_stage
      if (TAPS[i]) begin : g_tap
        assign step[i] = st[i-1] ^ fb ^ d_in[i];
      end else begin : g_plain
        assign step[i] = st[i-1] ^ d_in[i];
      end
    end
  endgenerate

  always_comb begin
    case (mode)
      M_SCAN:  nxt = {st[WIDTH-2:0], scan_in};
      M_SIG:   nxt = step;
      M_GEN:   nxt = (st == '0) ? ONE : step;
      M_LOAD:  nxt = par_in;
      default: nxt = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SEED;
    else     st <= nxt;
  end

  assign par_out  = st;
  assign scan_out = st[WIDTH-1];
endmodule

// File: rtl/bist_reg_chk.sv
module bist_reg_chk #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] SEED  = '0
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] par_in,
  input logic             scan_in,
  input logic [WIDTH-1:0] q,
  input logic             scan_out
);
  assert_seed_R1: assert property (@(posedge clk) rst |=> q == SEED);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> q == $past(par_in));

  assert_scan_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (q[0] == $past(scan_in)) && (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));

  assert_scan_out_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> scan_out == $past(q[WIDTH-2]));

  assert_gen_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && q != '0) |=> q[0] == $past(q[WIDTH-1]));

  assert_gen_escape_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && q == '0) |=> q == {{(WIDTH-1){1'b0}}, 1'b1});

  assert_gen_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && q != '0) |=> q != '0);

  assert_sig_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && q == '0 && par_in == '0) |=> q == '0);
endmodule

bind bist_reg bist_reg_chk #(.WIDTH(WIDTH), .SEED(SEED)) chk_i (
  .clk(clk), .rst(rst), .mode(mode), .par_in(par_in),
  .scan_in(scan_in), .q(st), .scan_out(scan_out)
);

// File: tb/bist_reg_tb_top.sv
`timescale 1ns/1ps
module bist_reg_tb_top;
  localparam int W = 8;
  localparam int FULL = 'h11D;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic [1:0] mode = 2'b11;
  logic [W-1:0] par_in = '0;
  logic scan_in = 1'b0;
  logic [W-1:0] par_out;
  logic scan_out;

  int checks = 0;
  int errors = 0;
  int model = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bist_reg #(.WIDTH(W), .TAPS(8'h1D), .SEED(8'h00)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .par_in(par_in),
    .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
  );

  function automatic int mulx(int s);
    int t = s << 1;
    if (t & (1 << W)) t = t ^ FULL;
    return t & MASK;
  endfunction

  function automatic int ref_next(int s, bit r, int m, int pin, bit si);
    if (r) return 0;
    case (m)
      0: return ((s << 1) | si) & MASK;
      1: return mulx(s) ^ pin;
      2: return (s == 0) ? 1 : mulx(s);
      default: return pin;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit r, int m, int pin, bit si);
    rst = r; mode = m[1:0]; par_in = pin[W-1:0]; scan_in = si;
    @(posedge clk);
    model = ref_next(model, r, m, pin, si);
    @(negedge clk);
    check(tag, int'(par_out), model);
    check(tag, int'(scan_out), (model >> (W-1)) & 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    bit hit_zero;
    bit bits [20];
    longint msg;
    @(negedge clk);
    model = 'h5A;
    // R1 reset seed, from any mode
    cyc("R1", 1, 2, 'hFF, 1);
    cyc("R1", 1, 0, 'h00, 1);
    // R2 parallel loads
    cyc("R2", 0, 3, 'hA5, 0);
    cyc("R2", 0, 3, 'h3C, 1);
    for (int i = 0; i < 6; i++) cyc("R2", 0, 3, (i * 37 + 11) & MASK, 0);
    // R3 scan shift, pattern in and out
    cyc("R3", 0, 3, 'hC3, 0);
    for (int i = 0; i < 16; i++) cyc("R3", 0, 0, 'hFF, ((i * 5) >> 1) & 1);
    // R5 zero escape then R4 stepping
    cyc("R1", 1, 3, 0, 0);
    cyc("R5", 0, 2, 'hFF, 1);
    check("R5", int'(par_out), 1);
    for (int i = 0; i < 20; i++) cyc("R4", 0, 2, i, i & 1);
    cyc("R2", 0, 3, 'h80, 0);
    cyc("R4", 0, 2, 0, 0);
    check("R4", int'(par_out), 'h1D);
    // R6 full period from state 1
    cyc("R2", 0, 3, 1, 0);
    cnt = 0; hit_zero = 0;
    do begin
      cyc("R6", 0, 2, 0, 0);
      cnt++;
      if (par_out == '0) hit_zero = 1;
    end while (par_out != 8'h01 && cnt < 300);
    check("R6", cnt, 255);
    check("R6", int'(hit_zero), 0);
    // R8 zero input keeps zero signature
    cyc("R1", 1, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R8", 0, 1, 0, 1);
    check("R8", int'(par_out), 0);
    // R7 serial stream remainder by long division
    msg = 0;
    for (int i = 0; i < 20; i++) begin
      bits[i] = ((i * 7 + 3) % 5) < 2;
      msg = (msg << 1) | longint'(bits[i]);
    end
    for (int i = 0; i < 20; i++) cyc("R7", 0, 1, int'(bits[i]), 0);
    for (int k = 19; k >= W; k--)
      if (msg[k]) msg = msg ^ (longint'(FULL) << (k - W));
    check("R7", int'(par_out), int'(msg & MASK));
    // R7 parallel words from a nonzero seed
    cyc("R2", 0, 3, 'h96, 0);
    for (int i = 0; i < 12; i++) cyc("R7", 0, 1, (i * 29 + 7) & MASK, 0);
    // R1 reset wins over pattern mode
    cyc("R1", 1, 2, 'h55, 0);
    check("R1", int'(par_out), 0);
    finish_run();
  end
endmodule